// File: doc/BRIEF.md
# Port Reset Sequencer for a Switch Management Controller

This block carries out the management command that controls the reset of a switch's physical ports. The switch has one upstream port and `N_DSP` downstream ports. Each request names a port by its identifier and gives an operation. The block then does one of three things. It can drive that port's fundamental reset (PERST) active, or release it. It can also fire a one-cycle cold-reset pulse at the port's bridge. Each request gets one status code back.

Once reset is driven, the port must stay in reset for a minimum hold. A shared prescaler produces a 1 ms tick, and a per-port counter counts the hold in those ticks. Until the hold has run out, the port refuses to be released. While the port is in reset at all, it refuses a second assert and it refuses a bridge reset. Each port's reset level and hold state are brought out so that a port-state readback can report them.

A small request state machine takes one request at a time. Its states are `RQ_IDLE` (ready) and `RQ_RESP` (response cycle). On acceptance it moves from `RQ_IDLE` to `RQ_RESP`, and it always returns to `RQ_IDLE` one cycle later. Each port has its own state machine:
- `PS_IDLE` moves to `PS_HOLD` on an accepted assert, which loads the counter with `HOLD_MS`.
- `PS_HOLD` stays put on each tick while the count is non-zero, counting down by one per tick.
- `PS_HOLD` moves to `PS_HELD` on a tick that finds the count at zero.
- `PS_HELD` moves to `PS_IDLE` on an accepted deassert, which reloads the counter.

Top module: `port_rst_ctrl`

## Requirements
- R1: After reset, `perst_o`, `hold_o` and `bridge_rst_o` are all zero, `rsp_valid` is low and `req_ready` is high.
- R2: A request with `req_len` below 2 returns status 2 (bad length). It changes no `perst_o` bit and produces no bridge pulse.
- R3: Port numbering is fixed. A `req_port` equal to `USP_ID` selects bit 0 of the per-port outputs, and a `req_port` of `DSP_BASE+k` (k from 0 to N_DSP-1) selects bit k+1. Any other identifier returns status 1 (bad input).
- R4: Operation 0 asserts reset, operation 1 releases it and operation 2 resets the bridge. Any other `req_op` value returns status 1 and changes no state.
- R5: An assert on a port whose reset is not active returns status 0. That port's `perst_o` and `hold_o` bits go high in the cycle after acceptance.
- R6: `hold_o` of a newly asserted port stays high for more than `HOLD_MS*TICK_DIV` and at most `(HOLD_MS+1)*TICK_DIV` clock cycles, and is only ever high while `perst_o` is high.
- R7: An assert on a port whose `perst_o` is high, whether still holding or held, returns status 3 (internal error).
- R8: A deassert returns status 3 unless the port's hold has completed (`perst_o` high, `hold_o` low). On success, `perst_o` of that port falls in the cycle after acceptance.
- R9: A bridge reset on a port whose `perst_o` is high returns status 3. Otherwise it returns status 0 and drives that port's `bridge_rst_o` bit high for exactly the one cycle after acceptance.
- R10: Every accepted request (`req_valid` with `req_ready`) is answered by `rsp_valid` high for exactly the next cycle. `req_ready` is low in that cycle. Status codes are 0 success, 1 bad input, 2 bad length and 3 internal error. The length check takes priority over the port check, which takes priority over the operation check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_port | input | 8 | Port identifier (payload byte 0) |
| req_op | input | 8 | Operation code (payload byte 1) |
| req_len | input | LEN_W | Payload length in bytes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | Completion status code |
| perst_o | output | N_DSP+1 | Per-port reset level, bit 0 upstream |
| hold_o | output | N_DSP+1 | Per-port minimum-hold countdown running |
| bridge_rst_o | output | N_DSP+1 | Per-port one-cycle bridge cold-reset pulse |

## Verification
The hold-ending tick and a deassert request for the same port can land on the same clock edge. The request is judged on the state before that edge, while the port moves to `PS_HELD` at that edge. The bench provokes this by sending deassert requests back to back while the hold runs, so that one of them meets the transition within a cycle. Each answer is judged against `hold_o` as seen just before its acceptance edge: internal error while the hold was still showing, success from the first request that found it clear. Only that success may drop `perst_o`.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_BAD_INPUT = 2'd1,
        ST_BAD_LEN   = 2'd2,
        ST_INT_ERR   = 2'd3
    } prc_status_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_HOLD = 2'd1,
        PS_HELD = 2'd2
    } port_state_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_RESP = 1'b1
    } req_state_e;

    localparam logic [7:0] OP_ASSERT   = 8'd0;
    localparam logic [7:0] OP_DEASSERT = 8'd1;
    localparam logic [7:0] OP_BRIDGE   = 8'd2;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/port_perst_fsm.sv
module port_perst_fsm
    import prc_pkg::*;
#(
    parameter int HOLD_MS = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        do_assert,
    input  logic        do_deassert,
    output port_state_e state_o
);
    localparam int CW = $clog2(HOLD_MS + 1);

    port_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            cnt_q <= CW'(HOLD_MS);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and hold counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PS_IDLE: begin
                if (do_assert) begin
                    st_d  = PS_HOLD;
                    cnt_d = CW'(HOLD_MS);
                end
            end
            PS_HOLD: begin
                if (tick) begin
                    if (cnt_q == '0) begin
                        st_d = PS_HELD;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            PS_HELD: begin
                if (do_deassert) begin
                    st_d  = PS_IDLE;
                    cnt_d = CW'(HOLD_MS);
                end
            end
            default: begin
                st_d  = PS_IDLE;
                cnt_d = CW'(HOLD_MS);
            end
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/req_decode.sv
module req_decode
    import prc_pkg::*;
#(
    parameter int NP       = 5,
    parameter int USP_ID   = 0,
    parameter int DSP_BASE = 1,
    parameter int LEN_W    = 16
) (
    input  logic [7:0]       req_port,
    input  logic [7:0]       req_op,
    input  logic [LEN_W-1:0] req_len,
    input  logic [NP-1:0]    idle_vec,
    input  logic [NP-1:0]    held_vec,
    output logic [NP-1:0]    sel,
    output prc_status_e      status,
    output logic             go_assert,
    output logic             go_deassert,
    output logic             go_bridge
);
    function automatic logic [7:0] port_id(input int idx);
        if (idx == 0) begin
            return 8'(USP_ID);
        end
        return 8'(DSP_BASE + idx - 1);
    endfunction

    always_comb begin
        sel = '0;
        for (int i = 0; i < NP; i++) begin
            if (req_port == port_id(i)) begin
                sel[i] = 1'b1;
            end
        end
    end

    always_comb begin
        status      = ST_OK;
        go_assert   = 1'b0;
        go_deassert = 1'b0;
        go_bridge   = 1'b0;
        if (req_len < LEN_W'(2)) begin
            status = ST_BAD_LEN;
        end else if (sel == '0) begin
            status = ST_BAD_INPUT;
        end else begin
            case (req_op)
                OP_ASSERT: begin
                    if ((sel & ~idle_vec) != '0) status = ST_INT_ERR;
                    else                         go_assert = 1'b1;
                end
                OP_DEASSERT: begin
                    if ((sel & held_vec) != '0) go_deassert = 1'b1;
                    else                        status = ST_INT_ERR;
                end
                OP_BRIDGE: begin
                    if ((sel & ~idle_vec) != '0) status = ST_INT_ERR;
                    else                         go_bridge = 1'b1;
                end
                default: status = ST_BAD_INPUT;
            endcase
        end
    end
endmodule

// File: rtl/port_rst_ctrl.sv
module port_rst_ctrl
    import prc_pkg::*;
#(
    parameter int N_DSP    = 4,
    parameter int USP_ID   = 0,
    parameter int DSP_BASE = 1,
    parameter int HOLD_MS  = 100,
    parameter int TICK_DIV = 125000,
    parameter int LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_port,
    input  logic [7:0]       req_op,
    input  logic [LEN_W-1:0] req_len,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [N_DSP:0]   perst_o,
    output logic [N_DSP:0]   hold_o,
    output logic [N_DSP:0]   bridge_rst_o
);
    localparam int NP = N_DSP + 1;

    req_state_e    rq_q, rq_d;
    prc_status_e   status_q, dec_status;
    logic [NP-1:0] bridge_q;
    logic [NP-1:0] sel, idle_vec, held_vec, asrt_vec, dasrt_vec;
    logic          accept, go_assert, go_deassert, go_bridge, tick;

    ms_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    req_decode #(
        .NP(NP), .USP_ID(USP_ID), .DSP_BASE(DSP_BASE), .LEN_W(LEN_W)
    ) u_dec (
        .req_port   (req_port),
        .req_op     (req_op),
        .req_len    (req_len),
        .idle_vec   (idle_vec),
        .held_vec   (held_vec),
        .sel        (sel),
        .status     (dec_status),
        .go_assert  (go_assert),
        .go_deassert(go_deassert),
        .go_bridge  (go_bridge)
    );

    assign accept    = req_valid && (rq_q == RQ_IDLE);
    assign asrt_vec  = sel & {NP{accept && go_assert}};
    assign dasrt_vec = sel & {NP{accept && go_deassert}};

    for (genvar g = 0; g < NP; g++) begin : g_port
        port_state_e st;
        port_perst_fsm #(.HOLD_MS(HOLD_MS)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .do_assert  (asrt_vec[g]),
            .do_deassert(dasrt_vec[g]),
            .state_o    (st)
        );
        assign idle_vec[g] = (st == PS_IDLE);
        assign held_vec[g] = (st == PS_HELD);
        assign perst_o[g]  = (st != PS_IDLE);
        assign hold_o[g]   = (st == PS_HOLD);
    end

    // Request state register
    always_ff @(posedge clk) begin
        if (!rst_n) rq_q <= RQ_IDLE;
        else        rq_q <= rq_d;
    end

    always_comb begin
        rq_d = rq_q;
        unique case (rq_q)
            RQ_IDLE: if (accept) rq_d = RQ_RESP;
            RQ_RESP: rq_d = RQ_IDLE;
            default: rq_d = RQ_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            bridge_q <= '0;
        end else begin
            if (accept) status_q <= dec_status;
            bridge_q <= (accept && go_bridge) ? sel : '0;
        end
    end

    assign req_ready    = (rq_q == RQ_IDLE);
    assign rsp_valid    = (rq_q == RQ_RESP);
    assign rsp_status   = status_q;
    assign bridge_rst_o = bridge_q;
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
    parameter int NP = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    rsp_status,
    input logic [NP-1:0] perst_o,
    input logic [NP-1:0] hold_o,
    input logic [NP-1:0] bridge_rst_o
);
    p_len_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> ($stable(perst_o) && bridge_rst_o == '0));

    p_rise_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((perst_o & ~$past(perst_o)) != '0) |-> (rsp_valid && rsp_status == 2'd0));

    p_hold_in_perst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o & ~perst_o) == '0);

    p_hold_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o & ~$past(hold_o) & $past(perst_o)) == '0);

    p_fall_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~perst_o & $past(perst_o)) != '0) |-> (rsp_valid && rsp_status == 2'd0));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_rst_o != '0) |=> (bridge_rst_o == '0));

    p_pulse_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_rst_o != '0) |-> ($countones(bridge_rst_o) == 1 && rsp_valid && rsp_status == 2'd0));

    p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind port_rst_ctrl prc_checker #(.NP(N_DSP + 1)) u_prc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .perst_o     (perst_o),
    .hold_o      (hold_o),
    .bridge_rst_o(bridge_rst_o)
);

// File: tb/tb_port_rst_ctrl.sv
module tb_port_rst_ctrl;
    localparam int N_DSP    = 3;
    localparam int NP       = N_DSP + 1;
    localparam int USP_ID   = 0;
    localparam int DSP_BASE = 4;
    localparam int HOLD_MS  = 100;
    localparam int TICK_DIV = 4;
    localparam int LEN_W    = 16;

    localparam logic [1:0] S_OK = 2'd0, S_IN = 2'd1, S_LEN = 2'd2, S_INT = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_port = '0, req_op = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_ready, rsp_valid;
    logic [1:0] rsp_status;
    logic [NP-1:0] perst_o, hold_o, bridge_rst_o;

    int checks = 0, errors = 0;
    bit reported = 0;
    int hold_len0 = 0;
    logic [1:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    port_rst_ctrl #(
        .N_DSP(N_DSP), .USP_ID(USP_ID), .DSP_BASE(DSP_BASE),
        .HOLD_MS(HOLD_MS), .TICK_DIV(TICK_DIV), .LEN_W(LEN_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_op(req_op), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .perst_o(perst_o),
        .hold_o(hold_o), .bridge_rst_o(bridge_rst_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: pops expected status on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected response", 1, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_status == e, t, rsp_status, e);
            end
        end
        if (hold_o[0]) hold_len0++;
    end

    // Driver: called at a negedge with the DUT idle; returns two negedges later
    task automatic send(input logic [7:0] p, input logic [7:0] op, input logic [LEN_W-1:0] len,
                        input logic [1:0] exp, input logic [NP-1:0] exp_br, input string tag);
        while (!req_ready) @(negedge clk);
        req_port  = p;
        req_op    = op;
        req_len   = len;
        req_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low in response cycle", req_ready, 0);
        chk(bridge_rst_o == exp_br, {tag, " R9 bridge pulse"}, bridge_rst_o, exp_br);
        @(negedge clk);
        chk(bridge_rst_o == '0, "R9 pulse one cycle", bridge_rst_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(perst_o == '0 && hold_o == '0 && bridge_rst_o == '0, "R1 per-port outputs", perst_o, 0);
        chk(!rsp_valid && req_ready, "R1 handshake", {rsp_valid, req_ready}, 1);

        // R2 short payload
        send(8'd4, 8'd0, 16'd1, S_LEN, '0, "R2 len1 assert");
        chk(perst_o == '0, "R2 no state change", perst_o, 0);
        send(8'd99, 8'd7, 16'd0, S_LEN, '0, "R2 len0 priority over port");
        // R3 unknown ports
        send(8'd1, 8'd0, 16'd2, S_IN, '0, "R3 port 1");
        send(8'd7, 8'd2, 16'd2, S_IN, '0, "R3 port 7");
        // R4 bad ops
        send(8'd4, 8'd3, 16'd2, S_IN, '0, "R4 op3");
        send(8'd0, 8'hFF, 16'd2, S_IN, '0, "R4 opFF");
        chk(perst_o == '0, "R4 no state change", perst_o, 0);
        // R8 deassert on idle port
        send(8'd4, 8'd1, 16'd2, S_INT, '0, "R8 deassert idle");
        // R9 bridge reset on idle downstream port 5 -> bit 2
        send(8'd5, 8'd2, 16'd2, S_OK, 4'b0100, "R9 bridge idle port5");
        // R5 assert upstream, longer payload accepted
        hold_len0 = 0;
        send(8'd0, 8'd0, 16'd3, S_OK, '0, "R5 assert usp");
        chk(perst_o[0] && hold_o[0], "R5 perst and hold set", {perst_o[0], hold_o[0]}, 3);
        send(8'd0, 8'd0, 16'd2, S_INT, '0, "R7 assert while holding");
        send(8'd0, 8'd2, 16'd2, S_INT, '0, "R9 bridge while holding");
        send(8'd0, 8'd1, 16'd2, S_INT, '0, "R8 deassert while holding");
        // R3 mapping: port 6 -> bit 3
        send(8'd6, 8'd0, 16'd2, S_OK, '0, "R5 assert port6");
        chk(perst_o == 4'b1001, "R3 bit mapping", perst_o, 4'b1001);
        // Race: deassert requests back to back across the hold end
        for (int k = 0; k < 1000; k++) begin
            logic [1:0] e;
            e = hold_o[0] ? S_INT : S_OK;
            send(8'd0, 8'd1, 16'd2, e, '0, "R8 deassert across hold end");
            if (e == S_OK) break;
            chk(perst_o[0] == 1'b1, "R8 perst kept on refusal", perst_o[0], 1);
        end
        chk(perst_o[0] == 1'b0, "R8 perst released", perst_o[0], 0);
        chk(hold_len0 > HOLD_MS * TICK_DIV && hold_len0 <= (HOLD_MS + 1) * TICK_DIV,
            "R6 hold duration", hold_len0, HOLD_MS * TICK_DIV);
        // Port 6 held
        while (hold_o[3]) @(negedge clk);
        chk(perst_o[3] == 1'b1, "R6 perst stays after hold", perst_o[3], 1);
        send(8'd6, 8'd0, 16'd2, S_INT, '0, "R7 assert while held");
        send(8'd6, 8'd2, 16'd2, S_INT, '0, "R9 bridge while held");
        send(8'd6, 8'd1, 16'd2, S_OK, '0, "R8 deassert held");
        chk(perst_o == '0, "R8 all released", perst_o, 0);
        send(8'd6, 8'd2, 16'd2, S_OK, 4'b1000, "R9 bridge after release");
        send(8'd0, 8'd0, 16'd2, S_OK, '0, "R5 reassert usp");
        chk(hold_o == 4'b0001, "R5 hold restarted", hold_o, 1);
        chk(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
        report();
    end
endmodule